// File: doc/BRIEF.md
# Channel Instruction Timing Sequencer

This block paces the interlock between a central processor and one data channel while a channel-related instruction runs. A free-running channel pulse counter splits time into frames of twelve numbered pulses. Each frame is labelled as a channel A, L, E or I cycle according to the flags that are live when it starts. A start strobe marks the processor pulse at which the processor drops its go flag. From that point the sequencer moves through the channel cycles at fixed pulse numbers and brings the go flag back when the processor may finish.

Two instruction classes are supported. An L-only instruction runs an L cycle and then an I cycle, and the go flag returns at the first pulse of the I cycle. An L-then-E instruction arms a proceed flag during the L cycle. It then enters the E cycle at the next A-cycle pulse 11, issues a one-cycle memory-address load strobe there, and returns the go flag inside the E cycle. A one-cycle done output tells the processor side that the operation has closed.

Top module: `chan_instr_seq`

## Requirements
- R1: A start accepted while idle clears `go` and sets `end_sync` on the next cycle; `end_sync` stays high until `go` is set again and clears on that same edge.
- R2: After a start, the first frame-A pulse 11 sets `l_time`; the following frame has `frame` code 1 (L) and starts at pulse 0.
- R3: For the L-only class (`need_e`=0), L-frame pulse 8 sets `le_end` and L-frame pulse 10 sets `i_time`, so the frame after the L frame has code 3 (I).
- R4: For the L-only class, I-frame pulse 0 sets `go`, and I-frame pulse 6 clears `i_time`.
- R5: For the L-then-E class (`need_e`=1), L-frame pulse 3 sets `proceed_e`; the next frame-A pulse 11 sets `e_time` and clears `proceed_e`; `i_time` never rises.
- R6: In the E frame (code 2), `mar_load` is high for exactly one cycle after pulse 2, and pulse 8 sets both `go` and `le_end`.
- R7: `done` is high for exactly one cycle per operation, one cycle after `go` is high with `i_time` low, and only while `go` is high.
- R8: A start that arrives while an operation is in progress is ignored, whatever its class.
- R9: `pulse` counts 0,1,...,11 and wraps to 0 once per cycle from reset; while idle `frame` stays at code 0 (A).
- R10: Reset sets `go` high, every other flag and `done` low, `pulse` to 0 and `frame` to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Processor pulse strobe that begins an operation |
| need_e | input | 1 | Instruction class: 0 L-only, 1 L then E |
| go | output | 1 | Processor go flag (low while the channel holds the processor) |
| end_sync | output | 1 | End-operation sync flag |
| l_time | output | 1 | Channel L-time flag |
| e_time | output | 1 | Channel E-time flag |
| i_time | output | 1 | Channel I-time flag |
| le_end | output | 1 | L-E end flag |
| proceed_e | output | 1 | Proceed-to-E flag |
| mar_load | output | 1 | One-cycle strobe sending the address to the memory address register |
| done | output | 1 | One-cycle operation-finished pulse |
| pulse | output | PW (4) | Channel pulse number within the frame |
| frame | output | 2 | Frame code: 0 A, 1 L, 2 E, 3 I |

## Verification
Every result is due a fixed number of cycles after the start edge, and that number depends only on the pulse number s at the start. With k = (11 - ((s+1) mod 12)) mod 12, the first cycle sampled after the start edge counts as index 0. For the L-only class, `l_time` is first seen at index k+1, `le_end` at k+10, `i_time` at k+12, `go` at k+14, the fall of `i_time` at k+20 and `done` at k+21. For the E class, `proceed_e` appears at k+5, `e_time` at k+25, `mar_load` at k+28, and `go`, `le_end` at k+34 with `done` at k+35. The bench drives inputs and samples on the falling edge, records the first index at which each output is seen, and compares it with these formulas.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [1:0] {
    FR_A = 2'd0,
    FR_L = 2'd1,
    FR_E = 2'd2,
    FR_I = 2'd3
  } frame_t;

  // pulse numbers at which the sequencer acts, within a frame
  localparam int PT_PROCEED = 3;
  localparam int PT_LE_END  = 8;
  localparam int PT_ITIME   = 10;
  localparam int PT_GO_I    = 0;
  localparam int PT_ICLR    = 6;
  localparam int PT_MAR     = 2;
  localparam int PT_GO_E    = 8;
endpackage

// File: rtl/chan_pulse_ctr.sv
module chan_pulse_ctr #(
  parameter int NPULSE = 12,
  localparam int PW = $clog2(NPULSE)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pulse,
  output logic          last
);
  localparam logic [PW-1:0] LASTP = PW'(NPULSE - 1);

  always_ff @(posedge clk) begin
    if (rst)              pulse <= '0;
    else if (pulse == LASTP) pulse <= '0;
    else                  pulse <= pulse + 1'b1;
  end

  assign last = (pulse == LASTP);

  assert_pulse_range_R9: assert property (@(posedge clk) disable iff (rst)
    pulse <= LASTP);
  assert_pulse_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    last |=> pulse == '0);
endmodule

// File: rtl/chan_flag_seq.sv
module chan_flag_seq
  import chan_seq_pkg::*;
#(
  parameter int NPULSE = 12,
  localparam int PW = $clog2(NPULSE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          need_e,
  input  logic [PW-1:0] pulse,
  input  logic          last,
  input  logic          done,
  output logic          go,
  output logic          end_sync,
  output logic          l_time,
  output logic          e_time,
  output logic          i_time,
  output logic          le_end,
  output logic          proceed_e,
  output logic          mar_load,
  output logic          active,
  output frame_t        frame
);
  logic   cls_e, pending;
  logic   go_n, sync_n, l_n, e_n, i_n, le_n, pe_n, mar_n, act_n, cls_n, pend_n;
  frame_t frame_n;

  function automatic logic at(input logic [PW-1:0] p, input int pt);
    return p == PW'(pt);
  endfunction

  always_comb begin
    go_n = go;   sync_n = end_sync; l_n = l_time; e_n = e_time;
    i_n = i_time; le_n = le_end; pe_n = proceed_e; mar_n = 1'b0;
    act_n = active; cls_n = cls_e; pend_n = pending; frame_n = frame;

    if (done) act_n = 1'b0;

    if (start && !active) begin
      act_n = 1'b1; go_n = 1'b0; sync_n = 1'b1;
      cls_n = need_e; le_n = 1'b0; pend_n = 1'b1;
    end

    unique case (frame)
      FR_A: if (last) begin
        if (pending) begin l_n = 1'b1; pend_n = 1'b0; end
        if (proceed_e) begin e_n = 1'b1; pe_n = 1'b0; end
      end
      FR_L: begin
        if (cls_e && at(pulse, PT_PROCEED)) pe_n = 1'b1;
        if (!cls_e && at(pulse, PT_LE_END)) le_n = 1'b1;
        if (!cls_e && at(pulse, PT_ITIME))  i_n  = 1'b1;
        if (last) l_n = 1'b0;
      end
      FR_E: begin
        if (at(pulse, PT_MAR)) mar_n = 1'b1;
        if (at(pulse, PT_GO_E)) begin go_n = 1'b1; le_n = 1'b1; sync_n = 1'b0; end
        if (last) e_n = 1'b0;
      end
      FR_I: begin
        if (at(pulse, PT_GO_I)) begin go_n = 1'b1; sync_n = 1'b0; end
        if (at(pulse, PT_ICLR)) i_n = 1'b0;
      end
    endcase

    if (last) begin
      if (l_n)      frame_n = FR_L;
      else if (e_n) frame_n = FR_E;
      else if (i_n) frame_n = FR_I;
      else          frame_n = FR_A;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go <= 1'b1; end_sync <= 1'b0; l_time <= 1'b0; e_time <= 1'b0;
      i_time <= 1'b0; le_end <= 1'b0; proceed_e <= 1'b0; mar_load <= 1'b0;
      active <= 1'b0; cls_e <= 1'b0; pending <= 1'b0; frame <= FR_A;
    end else begin
      go <= go_n; end_sync <= sync_n; l_time <= l_n; e_time <= e_n;
      i_time <= i_n; le_end <= le_n; proceed_e <= pe_n; mar_load <= mar_n;
      active <= act_n; cls_e <= cls_n; pending <= pend_n; frame <= frame_n;
    end
  end

  assert_go_drop_sync_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(go) |-> end_sync);
  assert_ltime_frame_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(l_time) |-> (pulse == '0) && (frame == FR_L));
  assert_cycle_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(e_time && (l_time || i_time)));
  assert_go_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(go) |-> ((frame == FR_I) && at(pulse, PT_GO_I + 1)) ||
                  ((frame == FR_E) && at(pulse, PT_GO_E + 1)));
  assert_mar_in_e_R6: assert property (@(posedge clk) disable iff (rst)
    mar_load |-> e_time && at(pulse, PT_MAR + 1));
endmodule

// File: rtl/chan_done_gen.sv
module chan_done_gen (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic go,
  input  logic i_time,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= active && go && !i_time && !done;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_go_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> go && !i_time);
endmodule

// File: rtl/chan_instr_seq.sv
module chan_instr_seq
  import chan_seq_pkg::*;
#(
  parameter int NPULSE = 12,
  localparam int PW = $clog2(NPULSE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          need_e,
  output logic          go,
  output logic          end_sync,
  output logic          l_time,
  output logic          e_time,
  output logic          i_time,
  output logic          le_end,
  output logic          proceed_e,
  output logic          mar_load,
  output logic          done,
  output logic [PW-1:0] pulse,
  output logic [1:0]    frame
);
  logic   last, active;
  frame_t frame_q;

  chan_pulse_ctr #(.NPULSE(NPULSE)) u_ctr (
    .clk(clk), .rst(rst), .pulse(pulse), .last(last)
  );

  chan_flag_seq #(.NPULSE(NPULSE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .need_e(need_e),
    .pulse(pulse), .last(last), .done(done),
    .go(go), .end_sync(end_sync), .l_time(l_time), .e_time(e_time),
    .i_time(i_time), .le_end(le_end), .proceed_e(proceed_e),
    .mar_load(mar_load), .active(active), .frame(frame_q)
  );

  chan_done_gen u_done (
    .clk(clk), .rst(rst), .active(active), .go(go),
    .i_time(i_time), .done(done)
  );

  assign frame = frame_q;
endmodule

// File: tb/sim_chan_instr_seq.sv
module sim_chan_instr_seq;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // {need_e, restart_midway, start pulse[3:0]}
  localparam logic [5:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0}, {1'b0, 1'b0, 4'd10}, {1'b1, 1'b0, 4'd3},
    {1'b1, 1'b0, 4'd11}, {1'b0, 1'b1, 4'd5}, {1'b1, 1'b1, 4'd7}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, need_e = 1'b0;
  logic go, end_sync, l_time, e_time, i_time, le_end, proceed_e, mar_load, done;
  logic [3:0] pulse;
  logic [1:0] frame;
  int nchk = 0, nfail = 0, cyc = 0;

  chan_instr_seq u0 (
    .clk(clk), .rst(rst), .start(start), .need_e(need_e), .go(go),
    .end_sync(end_sync), .l_time(l_time), .e_time(e_time), .i_time(i_time),
    .le_end(le_end), .proceed_e(proceed_e), .mar_load(mar_load), .done(done),
    .pulse(pulse), .frame(frame)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 go", go, 1);
    chk("R10 flags", {end_sync, l_time, e_time, i_time, le_end, proceed_e, mar_load, done}, 0);
    chk("R10 pulse", pulse, 0);
    chk("R10 frame", frame, 0);
    rst = 1'b0;

    // R9: counter from reset, idle frame A
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      chk("R9 pulse", pulse, n % 12);
      chk("R9 frame", frame, 0);
    end

    for (int v = 0; v < NV; v++) begin
      logic ne, rs;
      int sp, k, lf, lef, ifst, ifall, gf, df, pf, ef, mf, dcnt, mcnt, sync_at_go, sync_pre;
      logic prev_i, prev_go;
      ne = VEC[v][5]; rs = VEC[v][4]; sp = int'(VEC[v][3:0]);
      while (int'(pulse) != sp) @(negedge clk);
      start = 1'b1; need_e = ne;
      @(negedge clk);
      start = 1'b0; need_e = 1'b0;
      k = (11 - ((sp + 1) % 12)) % 12;
      lf = -1; lef = -1; ifst = -1; ifall = -1; gf = -1; df = -1; pf = -1; ef = -1; mf = -1;
      dcnt = 0; mcnt = 0; sync_at_go = -1; sync_pre = -1; prev_i = 1'b0; prev_go = 1'b0;
      for (int i = 0; i < 52; i++) begin
        if (i == 0) begin
          chk("R1 go low after start", go, 0);
          chk("R1 end_sync high after start", end_sync, 1);
        end
        if (l_time && lf < 0) lf = i;
        if (lf == i) chk("R2 L frame code", frame, 1);
        if (le_end && lef < 0) lef = i;
        if (i_time && ifst < 0) ifst = i;
        if (prev_i && !i_time && ifall < 0) ifall = i;
        if (proceed_e && pf < 0) pf = i;
        if (e_time && ef < 0) ef = i;
        if (go && gf < 0) begin gf = i; sync_at_go = end_sync; end
        if (!go) sync_pre = end_sync;
        if (done) begin dcnt++; if (df < 0) df = i; end
        if (mar_load) begin mcnt++; if (mf < 0) mf = i; end
        prev_i = i_time; prev_go = go;
        if (rs && i == 5) begin start = 1'b1; need_e = !ne; end
        if (rs && i == 6) begin start = 1'b0; need_e = 1'b0; end
        @(negedge clk);
      end
      chk("R2 l_time first index", lf, k + 1);
      chk("R1 end_sync before go", sync_pre, 1);
      chk("R1 end_sync cleared with go", sync_at_go, 0);
      chk("R7 done count (R8 restart ignored)", dcnt, 1);
      if (!ne) begin
        chk("R3 le_end at L8", lef, k + 10);
        chk("R3 i_time at L10", ifst, k + 12);
        chk("R4 go at I0", gf, k + 14);
        chk("R4 i_time clear at I6", ifall, k + 20);
        chk("R7 done index", df, k + 21);
        chk("R8 no mar_load in L-only", mcnt, 0);
        chk("R3 no proceed in L-only", pf, -1);
      end else begin
        chk("R5 proceed at L3", pf, k + 5);
        chk("R5 e_time at next A11", ef, k + 25);
        chk("R5 i_time never", ifst, -1);
        chk("R6 mar_load index", mf, k + 28);
        chk("R6 mar_load one cycle", mcnt, 1);
        chk("R6 go at E8", gf, k + 34);
        chk("R6 le_end at E8", lef, k + 34);
        chk("R7 done index", df, k + 35);
      end
      chk("R5 proceed cleared at end", proceed_e, 0);
      chk("R9 frame back to A", frame, 0);
    end

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule